// File: doc/BRIEF.md
# Multichannel ADC scan sequencer

This block sweeps one shared analog-to-digital converter across up to eight input channels under register control. Software programs a channel mask and sets a start bit. The block then converts every selected channel, one after another, and writes each result into that channel's result register. It marks each finished channel in a status register. At the end of a sweep it raises a done flag, and for one-shot sweeps it also raises an interrupt.

There are two sweep modes, and each has its own mask and its own done flag. A one-shot sweep starts on a rising edge of its start bit. A repeating sweep runs while its start bit stays set, with a programmable idle gap between sweeps. For each conversion the block drives the active channel number to the converter, along with that channel's reference choice, the resolution setting and the differential-mode setting. The converter itself sits outside the block and answers each start pulse with a one-cycle done pulse that carries the result.

Top module: `adc_scan_seq`

## Requirements
- R1: The byte addresses are: control 0x00, gap delay 0x04, status 0x08, one-shot mask 0x0C, repeat mask 0x10, channel n result at 0x14+4n, general config 0x7C, reference select 0x80, reference control 0x84 and converter settings 0x88. Delay (low 16 bits), config and reference control read back what was written.
- R2: Each conversion begins with a one-cycle `cnv_start` pulse while `cnv_chan` holds the channel number. The `cnv_result` value present on the `cnv_done` pulse is stored, zero-extended, in that channel's result register.
- R3: A sweep converts only the channels whose mask bit is set, in ascending channel order.
- R4: Both channel masks are 8 bits wide. Written bits 31:8 are dropped and read back as zero.
- R5: Status bit n is set when channel n's result is stored. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: Control bit 0 is activate and bit 1 is start one-shot. A one-shot sweep starts only on a 0-to-1 change of bit 1 while bit 0 is 1. A start bit held at 1 starts nothing more. When the sweep ends, control bit 7 is set. An empty mask sets bit 7 without any conversion.
- R7: Control bits 7 (one-shot done) and 6 (repeat done) are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: `irq` is high exactly while control bit 7 is set. Repeat sweeps never raise it.
- R9: While control bits 0 and 2 are both 1, sweeps of the repeat mask run back to back. Each sweep sets bit 6. From the done pulse of one sweep's last conversion to the next sweep's first start pulse, the gap is the delay value plus 4 cycles. Clearing bit 2 stops the sequence after the sweep in progress.
- R10: Converter settings bit 0 = 1 selects 12-bit resolution (0 selects 10-bit), and bit 1 enables differential mode. Both are driven on `cnv_res12` and `cnv_diff` during every conversion.
- R11: Reference select bit n = 1 picks the external reference for channel n, and 0 picks the internal pad reference. The bit for the active channel is driven on `cnv_ext_ref`.
- R12: Writing 1 to control bit 4 (soft reset) returns the sequencer to idle. It clears status, both done flags, all result registers and both start bits, and it keeps bits 0 and 3 as written. A done pulse that arrives later is ignored. Bit 4 always reads 0.
- R13: After `rst_n` low, control and status read 0, `irq` is low and `cnv_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cnv_start | output | 1 | One-cycle conversion request |
| cnv_chan | output | 3 | Channel being converted |
| cnv_ext_ref | output | 1 | External reference chosen for the active channel |
| cnv_res12 | output | 1 | 12-bit resolution when high, 10-bit when low |
| cnv_diff | output | 1 | Differential mode enable |
| cnv_done | input | 1 | One-cycle conversion complete pulse |
| cnv_result | input | 12 | Conversion result, valid with `cnv_done` |
| irq | output | 1 | One-shot sweep complete interrupt |

## Verification
The bench sends masks with scattered, top-only, full and empty patterns. It checks that the conversion order climbs and skips unselected channels; a wrong priority pick would reorder or repeat channels. It tries to start a sweep with activate low and with a start bit that is already high; a level-triggered start would sweep again. It measures the gap between repeat sweeps to the exact cycle and stops a repeat sequence partway, which catches an off-by-one delay counter or a sequencer that ignores the stop. It also fires a soft reset while a conversion is in flight and then delivers the late done pulse; a design that still accepts that pulse would write a stale result after the reset.

// File: rtl/adc_scan_pkg.sv
// Shared constants and types for the ADC scan sequencer.
// Assumes byte addressing with 32-bit registers on word boundaries.
package adc_scan_pkg;
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_DELAY  = 'h04;
    localparam int OFF_STATUS = 'h08;
    localparam int OFF_SMASK  = 'h0C;
    localparam int OFF_RMASK  = 'h10;
    localparam int OFF_RES0   = 'h14;
    localparam int OFF_CFG    = 'h7C;
    localparam int OFF_REFSEL = 'h80;
    localparam int OFF_REFCTL = 'h84;
    localparam int OFF_CNV    = 'h88;

    localparam int BIT_ACT   = 0;
    localparam int BIT_SGL   = 1;
    localparam int BIT_REP   = 2;
    localparam int BIT_PWR   = 3;
    localparam int BIT_SRST  = 4;
    localparam int BIT_RDONE = 6;
    localparam int BIT_SDONE = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WAIT,
        ST_GAP
    } seq_state_t;
endpackage

// File: rtl/adc_scan_pick.sv
// Lowest-set-bit finder: reports whether any request is set and the index
// of the lowest one. Pure combinational; no assumptions on the input.
module adc_scan_pick #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [CH_W-1:0]   idx
);
    // Scan from the top down so the lowest set bit is the last one kept.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
    end
endmodule

// File: rtl/adc_scan_regs.sv
// Register file of the scan sequencer: control, masks, delay, status,
// per-channel results and converter settings. Takes completion events from
// the sweep controller. Assumes single-cycle writes; reads are combinational.
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CH_W     = 3,
    parameter int RESULT_W = 12,
    parameter int DELAY_W  = 16,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                evt_wr,
    input  logic [CH_W-1:0]     evt_ch,
    input  logic [RESULT_W-1:0] evt_data,
    input  logic                evt_sdone,
    input  logic                evt_rdone,
    output logic                act,
    output logic                start_single,
    output logic                start_repeat,
    output logic [NUM_CH-1:0]   smask,
    output logic [NUM_CH-1:0]   rmask,
    output logic [DELAY_W-1:0]  delay,
    output logic [NUM_CH-1:0]   refsel,
    output logic                res12,
    output logic                diff,
    output logic                srst,
    output logic                irq
);
    logic                pwr_q, sdone_q, rdone_q;
    logic [NUM_CH-1:0]   status_q;
    logic [31:0]         cfg_q, refctl_q;
    logic [1:0]          cnv_q;
    logic [RESULT_W-1:0] result_q [NUM_CH];
    logic                wr_ctrl, wr_status;
    logic [NUM_CH-1:0]   set_vec, clr_vec;

    assign wr_ctrl   = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
    assign wr_status = reg_we && (reg_addr == ADDR_W'(OFF_STATUS));
    assign srst      = wr_ctrl && reg_wdata[BIT_SRST];
    assign set_vec   = evt_wr ? ({{(NUM_CH-1){1'b0}}, 1'b1} << evt_ch) : '0;
    assign clr_vec   = wr_status ? reg_wdata[NUM_CH-1:0] : '0;
    assign irq       = sdone_q;
    assign res12     = cnv_q[0];
    assign diff      = cnv_q[1];

    // Control bits: stored fields, self-clearing soft reset, sticky done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0; start_single <= 1'b0; start_repeat <= 1'b0;
            pwr_q <= 1'b0; sdone_q <= 1'b0; rdone_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                act          <= reg_wdata[BIT_ACT];
                start_single <= reg_wdata[BIT_SGL] & ~reg_wdata[BIT_SRST];
                start_repeat <= reg_wdata[BIT_REP] & ~reg_wdata[BIT_SRST];
                pwr_q        <= reg_wdata[BIT_PWR];
            end
            if (srst)                               sdone_q <= 1'b0;
            else if (evt_sdone)                     sdone_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[BIT_SDONE]) sdone_q <= 1'b0;
            if (srst)                               rdone_q <= 1'b0;
            else if (evt_rdone)                     rdone_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[BIT_RDONE]) rdone_q <= 1'b0;
        end
    end

    // Plain configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay <= '0; smask <= '0; rmask <= '0; cfg_q <= '0;
            refsel <= '0; refctl_q <= '0; cnv_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_W'(OFF_DELAY):  delay    <= reg_wdata[DELAY_W-1:0];
                ADDR_W'(OFF_SMASK):  smask    <= reg_wdata[NUM_CH-1:0];
                ADDR_W'(OFF_RMASK):  rmask    <= reg_wdata[NUM_CH-1:0];
                ADDR_W'(OFF_CFG):    cfg_q    <= reg_wdata;
                ADDR_W'(OFF_REFSEL): refsel   <= reg_wdata[NUM_CH-1:0];
                ADDR_W'(OFF_REFCTL): refctl_q <= reg_wdata;
                ADDR_W'(OFF_CNV):    cnv_q    <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    // Status: hardware set wins over a simultaneous write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) status_q <= '0;
        else                status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // One result register per channel, written on that channel's completion.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_result
        always_ff @(posedge clk) begin
            if (!rst_n || srst)                        result_q[g] <= '0;
            else if (evt_wr && (evt_ch == CH_W'(g)))   result_q[g] <= evt_data;
        end
    end

    // Read multiplexer over all registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_CTRL): begin
                reg_rdata[BIT_ACT]   = act;
                reg_rdata[BIT_SGL]   = start_single;
                reg_rdata[BIT_REP]   = start_repeat;
                reg_rdata[BIT_PWR]   = pwr_q;
                reg_rdata[BIT_RDONE] = rdone_q;
                reg_rdata[BIT_SDONE] = sdone_q;
            end
            ADDR_W'(OFF_DELAY):  reg_rdata[DELAY_W-1:0] = delay;
            ADDR_W'(OFF_STATUS): reg_rdata[NUM_CH-1:0]  = status_q;
            ADDR_W'(OFF_SMASK):  reg_rdata[NUM_CH-1:0]  = smask;
            ADDR_W'(OFF_RMASK):  reg_rdata[NUM_CH-1:0]  = rmask;
            ADDR_W'(OFF_CFG):    reg_rdata              = cfg_q;
            ADDR_W'(OFF_REFSEL): reg_rdata[NUM_CH-1:0]  = refsel;
            ADDR_W'(OFF_REFCTL): reg_rdata              = refctl_q;
            ADDR_W'(OFF_CNV):    reg_rdata[1:0]         = cnv_q;
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (reg_addr == ADDR_W'(OFF_RES0 + 4 * i))
                        reg_rdata[RESULT_W-1:0] = result_q[i];
                end
            end
        endcase
    end

    // R8: the interrupt drops only on a done clear or a soft reset.
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !srst && !(wr_ctrl && reg_wdata[BIT_SDONE])) |=> irq);

    // R5: a stored result always leaves a status bit set.
    assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && !srst) |=> (status_q != '0));

    // R12: soft reset empties status and both done flags.
    assert_srst_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (status_q == '0 && !sdone_q && !rdone_q));
endmodule

// File: rtl/adc_scan_ctrl.sv
// Sweep controller: walks the latched mask from the lowest channel up,
// issues one converter request per channel, waits for its done pulse,
// and inserts the programmed gap between repeat sweeps.
// Assumes the converter returns exactly one done pulse per start pulse.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CH_W     = 3,
    parameter int RESULT_W = 12,
    parameter int DELAY_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                srst,
    input  logic                act,
    input  logic                start_single,
    input  logic                start_repeat,
    input  logic [NUM_CH-1:0]   smask,
    input  logic [NUM_CH-1:0]   rmask,
    input  logic [DELAY_W-1:0]  delay,
    input  logic                cnv_done,
    input  logic [RESULT_W-1:0] cnv_result,
    output logic                cnv_start,
    output logic [CH_W-1:0]     cnv_chan,
    output logic                evt_wr,
    output logic [CH_W-1:0]     evt_ch,
    output logic [RESULT_W-1:0] evt_data,
    output logic                evt_sdone,
    output logic                evt_rdone
);
    seq_state_t         state;
    logic [NUM_CH-1:0]  pending;
    logic               mode_rep, single_prev, in_sweep;
    logic [CH_W-1:0]    cur_ch, last_ch;
    logic [DELAY_W-1:0] gap_cnt;
    logic               pend_any;
    logic [CH_W-1:0]    pick_idx;

    adc_scan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .req (pending),
        .any (pend_any),
        .idx (pick_idx)
    );

    assign cnv_chan  = cur_ch;
    assign evt_wr    = (state == ST_WAIT) && cnv_done;
    assign evt_ch    = cur_ch;
    assign evt_data  = cnv_result;
    assign evt_sdone = (state == ST_SCAN) && !pend_any && !mode_rep;
    assign evt_rdone = (state == ST_SCAN) && !pend_any && mode_rep;

    // Sweep state machine with start-edge detection and gap counting.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            state <= ST_IDLE; pending <= '0; mode_rep <= 1'b0;
            single_prev <= 1'b0; in_sweep <= 1'b0; cur_ch <= '0;
            last_ch <= '0; gap_cnt <= '0; cnv_start <= 1'b0;
        end else begin
            cnv_start   <= 1'b0;
            single_prev <= start_single;
            case (state)
                ST_IDLE: begin
                    in_sweep <= 1'b0;
                    if (act && start_single && !single_prev) begin
                        pending <= smask; mode_rep <= 1'b0; state <= ST_SCAN;
                    end else if (act && start_repeat) begin
                        pending <= rmask; mode_rep <= 1'b1; state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pend_any) begin
                        cur_ch    <= pick_idx;
                        last_ch   <= pick_idx;
                        in_sweep  <= 1'b1;
                        pending   <= pending & ~({{(NUM_CH-1){1'b0}}, 1'b1} << pick_idx);
                        cnv_start <= 1'b1;
                        state     <= ST_WAIT;
                    end else if (mode_rep && act && start_repeat) begin
                        gap_cnt  <= delay;
                        in_sweep <= 1'b0;
                        state    <= ST_GAP;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (cnv_done) state <= ST_SCAN;
                end
                ST_GAP: begin
                    if (!(act && start_repeat)) begin
                        state <= ST_IDLE;
                    end else if (gap_cnt == '0) begin
                        pending <= rmask; state <= ST_SCAN;
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a conversion request lasts one cycle.
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    // R3: within a sweep each new channel is above the previous one.
    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && pend_any && in_sweep) |-> (pick_idx > last_ch));
endmodule

// File: rtl/adc_scan_seq.sv
// Top of the ADC scan sequencer: register file plus sweep controller,
// with the active channel's reference choice and the shared converter
// settings forwarded to the external converter.
module adc_scan_seq #(
    parameter int NUM_CH   = 8,
    parameter int RESULT_W = 12,
    parameter int DELAY_W  = 16,
    parameter int ADDR_W   = 8,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                cnv_start,
    output logic [CH_W-1:0]     cnv_chan,
    output logic                cnv_ext_ref,
    output logic                cnv_res12,
    output logic                cnv_diff,
    input  logic                cnv_done,
    input  logic [RESULT_W-1:0] cnv_result,
    output logic                irq
);
    logic                act, start_single, start_repeat, srst;
    logic [NUM_CH-1:0]   smask, rmask, refsel;
    logic [DELAY_W-1:0]  delay;
    logic                evt_wr, evt_sdone, evt_rdone;
    logic [CH_W-1:0]     evt_ch;
    logic [RESULT_W-1:0] evt_data;

    adc_scan_regs #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .RESULT_W(RESULT_W),
        .DELAY_W(DELAY_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .evt_wr, .evt_ch, .evt_data, .evt_sdone, .evt_rdone,
        .act, .start_single, .start_repeat, .smask, .rmask, .delay,
        .refsel, .res12(cnv_res12), .diff(cnv_diff), .srst, .irq
    );

    adc_scan_ctrl #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .RESULT_W(RESULT_W), .DELAY_W(DELAY_W)
    ) u_ctrl (
        .clk, .rst_n, .srst, .act, .start_single, .start_repeat,
        .smask, .rmask, .delay, .cnv_done, .cnv_result,
        .cnv_start, .cnv_chan, .evt_wr, .evt_ch, .evt_data,
        .evt_sdone, .evt_rdone
    );

    // Reference choice of the channel currently being converted.
    assign cnv_ext_ref = refsel[cnv_chan];
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] mask;
        logic [7:0] refsel;
        logic [1:0] cnv;
        logic [3:0] nconv;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h01, 8'h00, 2'd0, 4'd1},
        '{8'h80, 8'h80, 2'd1, 4'd1},
        '{8'hA5, 8'h0F, 2'd2, 4'd4},
        '{8'hFF, 8'h55, 2'd3, 4'd8},
        '{8'h18, 8'hFF, 2'd1, 4'd2},
        '{8'h42, 8'h02, 2'd0, 4'd2}
    };

    logic        clk = 0, rst_n = 0, reg_we = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        cnv_start, cnv_ext_ref, cnv_res12, cnv_diff, irq;
    logic [2:0]  cnv_chan;
    logic        cnv_done = 0;
    logic [11:0] cnv_result = 0;

    int checks = 0, errors = 0;
    int cnv_lat = 3, cyc = 0, rec_n = 0, pend_cnt = 0;
    int busy_ch = 0;
    logic [3:0] res_tag = 0;
    int   rec_ch [64], rec_cyc [64], rec_done [64];
    logic rec_ext [64], rec_r12 [64], rec_dif [64];
    logic [31:0] rd_v;
    bit done_flag = 0;

    adc_scan_seq dut (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .cnv_start, .cnv_chan, .cnv_ext_ref, .cnv_res12, .cnv_diff,
        .cnv_done, .cnv_result, .irq
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [11:0] conv_val(int ch);
        return {res_tag, 4'h5, 4'(ch)};
    endfunction

    // Behavioural converter: answers each start with a done after cnv_lat.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            cnv_done = 0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    cnv_done = 1;
                    cnv_result = conv_val(busy_ch);
                    if (rec_n > 0 && rec_n <= 64) rec_done[rec_n-1] = cyc;
                end
            end
            if (cnv_start) begin
                busy_ch = int'(cnv_chan);
                pend_cnt = cnv_lat;
                if (rec_n < 64) begin
                    rec_ch[rec_n] = int'(cnv_chan);
                    rec_ext[rec_n] = cnv_ext_ref;
                    rec_r12[rec_n] = cnv_res12;
                    rec_dif[rec_n] = cnv_diff;
                    rec_cyc[rec_n] = cyc;
                end
                rec_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit && !irq; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (done_flag) return;
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R13 reset state
        rd(8'h00, rd_v); chk(rd_v == 0, "R13 ctrl", rd_v, 0);
        rd(8'h08, rd_v); chk(rd_v == 0, "R13 status", rd_v, 0);
        chk(irq == 0 && cnv_start == 0, "R13 irq/start", {irq, cnv_start}, 0);

        // R1 register map read-back
        wr(8'h04, 32'hABCD1234); rd(8'h04, rd_v); chk(rd_v == 32'h1234, "R1 delay", rd_v, 32'h1234);
        wr(8'h7C, 32'hDEADBEEF); rd(8'h7C, rd_v); chk(rd_v == 32'hDEADBEEF, "R1 config", rd_v, 32'hDEADBEEF);
        wr(8'h84, 32'h0000C0DE); rd(8'h84, rd_v); chk(rd_v == 32'hC0DE, "R1 refctl", rd_v, 32'hC0DE);
        wr(8'h00, 32'h19); rd(8'h00, rd_v); chk(rd_v == 32'h09, "R1 ctrl srst reads 0", rd_v, 32'h09);

        // R4 mask width
        wr(8'h0C, 32'hFFFFFF05); rd(8'h0C, rd_v); chk(rd_v == 32'h05, "R4 smask", rd_v, 32'h05);
        wr(8'h10, 32'h12345606); rd(8'h10, rd_v); chk(rd_v == 32'h06, "R4 rmask", rd_v, 32'h06);

        // R6 start ignored with activate low, then a held start bit
        wr(8'h00, 32'h0); rec_n = 0;
        wr(8'h00, 32'h2); idle(30);
        chk(rec_n == 0 && irq == 0, "R6 no sweep when inactive", rec_n, 0);
        wr(8'h00, 32'h3); idle(30);
        chk(rec_n == 0 && irq == 0, "R6 held start no sweep", rec_n, 0);

        // Vector table: one-shot sweeps (R2 R3 R5 R6 R7 R8 R10 R11)
        for (int v = 0; v < 6; v++) begin
            int k;
            wr(8'h00, 32'h1);
            wr(8'h80, {24'h0, VECS[v].refsel});
            wr(8'h88, {30'h0, VECS[v].cnv});
            wr(8'h0C, {24'h0, VECS[v].mask});
            res_tag = 4'(v + 1);
            rec_n = 0;
            wr(8'h00, 32'h3);
            wait_irq(500);
            idle(5);
            chk(rec_n == int'(VECS[v].nconv), "R3 conversion count", rec_n, VECS[v].nconv);
            k = 0;
            for (int ch = 0; ch < 8; ch++) begin
                if (VECS[v].mask[ch] && k < 64) begin
                    chk(rec_ch[k] == ch, "R3 ascending order", rec_ch[k], ch);
                    chk(rec_ext[k] == VECS[v].refsel[ch], "R11 ref select", rec_ext[k], VECS[v].refsel[ch]);
                    chk(rec_r12[k] == VECS[v].cnv[0] && rec_dif[k] == VECS[v].cnv[1],
                        "R10 res/diff", {rec_dif[k], rec_r12[k]}, VECS[v].cnv);
                    rd(8'(8'h14 + 4 * ch), rd_v);
                    chk(rd_v == {20'h0, conv_val(ch)}, "R2 result", rd_v, conv_val(ch));
                    k++;
                end
            end
            rd(8'h08, rd_v); chk(rd_v == {24'h0, VECS[v].mask}, "R5 status", rd_v, VECS[v].mask);
            rd(8'h00, rd_v); chk(rd_v[7] == 1, "R6 single done", rd_v, 32'h83);
            wr(8'h00, 32'h3); idle(10);
            chk(irq == 1, "R8 irq held / R7 write 0 keeps", irq, 1);
            wr(8'h08, 32'hFF); rd(8'h08, rd_v); chk(rd_v == 0, "R5 status W1C", rd_v, 0);
            wr(8'h00, 32'h81); rd(8'h00, rd_v);
            chk(rd_v == 32'h01 && irq == 0, "R7 sdone W1C / R8 irq low", rd_v, 32'h01);
        end

        // R6 empty mask completes with no conversion
        wr(8'h0C, 32'h0); rec_n = 0;
        wr(8'h00, 32'h3); wait_irq(50);
        chk(irq == 1 && rec_n == 0, "R6 empty mask", rec_n, 0);
        wr(8'h00, 32'h81);

        // R9 repeat mode: gap timing, done flag, stop after current sweep
        wr(8'h10, 32'h06); wr(8'h04, 32'd5); rec_n = 0;
        wr(8'h00, 32'h5);
        for (int i = 0; i < 1000 && rec_n < 6; i++) @(negedge clk);
        chk(irq == 0, "R8 no irq in repeat", irq, 0);
        wr(8'h00, 32'h1); idle(80);
        chk(rec_n % 2 == 0 && rec_n >= 6 && rec_n <= 8, "R9 stop after sweep", rec_n, 6);
        chk(rec_ch[2] == 1 && rec_ch[3] == 2, "R9 repeat mask order", rec_ch[3], 2);
        chk(rec_cyc[2] - rec_done[1] == 9, "R9 gap cycles", rec_cyc[2] - rec_done[1], 9);
        rd(8'h00, rd_v); chk(rd_v[6] == 1, "R9 repeat done", rd_v, 32'h41);
        wr(8'h00, 32'h41); rd(8'h00, rd_v); chk(rd_v == 32'h01, "R7 rdone W1C", rd_v, 32'h01);

        // R12 soft reset mid-conversion with a late done pulse
        cnv_lat = 40; res_tag = 4'hE;
        wr(8'h0C, 32'h03); rec_n = 0;
        wr(8'h00, 32'h3);
        for (int i = 0; i < 100 && rec_n < 1; i++) @(negedge clk);
        idle(5);
        wr(8'h00, 32'h11);
        idle(80);
        chk(rec_n == 1, "R12 sweep stopped", rec_n, 1);
        rd(8'h00, rd_v); chk(rd_v == 32'h01, "R12 ctrl after srst", rd_v, 32'h01);
        rd(8'h08, rd_v); chk(rd_v == 0, "R12 status cleared", rd_v, 0);
        for (int ch = 0; ch < 8; ch++) begin
            rd(8'(8'h14 + 4 * ch), rd_v);
            chk(rd_v == 0, "R12 result cleared", rd_v, 0);
        end
        chk(irq == 0, "R12 irq low", irq, 0);
        cnv_lat = 3;

        finish_run();
    end
endmodule